// File: doc/BRIEF.md
# Branch and Return Resolution Unit

This unit decides where a 32-bit core with branch delay slots fetches next, for every control-transfer instruction. The decode stage presents a resolved request for one cycle. The request carries the branch address, the first register operand, and the offset or target value, already selected from a register or an immediate. It also carries the branch kind and its modifiers. One clock later the unit returns a registered result. The result holds the next fetch address, whether the transfer was taken, and whether the following instruction occupies a delay slot. It also holds a link write of the branch address, and set and clear masks for the machine status register.

Four kinds of request are handled:
- **Unconditional jumps.** Relative or absolute, with optional link and optional delay slot.
- **Conditional branches.** A signed comparison of the register operand against zero, relative target only.
- **Breaks.** These link, jump to an absolute target and raise the break-in-progress status bit.
- **Returns.** These jump to register plus offset, always with a delay slot. Returning from an interrupt sets the interrupt-enable bit. Returning from a break clears the break-in-progress bit.

Register storage, fetch and execution of the delay-slot instruction are left to the surrounding pipeline.

Top module: `branch_resolve`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is driven to zero at that edge.
- R2: A request with `in_valid` high produces its result with `out_valid` high exactly one clock later. A clock with `in_valid` low yields `out_valid` low with every other output zero.
- R3: With `br_kind` = 1 (conditional), `cond_code` selects a signed test of `reg_a` against zero:
  - 0 tests equal.
  - 1 tests not equal.
  - 2 tests less than.
  - 3 tests less or equal.
  - 4 tests greater than.
  - 5 tests greater or equal.
- R4: A conditional branch that holds gives `taken` = 1 and `next_pc` = `cur_pc` + `operand`. One that fails gives `taken` = 0 and `next_pc` = `cur_pc` + 4, with the sum wrapping modulo 2^32.
- R5: With `br_kind` = 0 (jump), `taken` is 1. `next_pc` is `operand` when `absolute` = 1, otherwise `cur_pc` + `operand`.
- R6: `link_we` is 1 only for a jump with `link` = 1, or for a break. Whenever `link_we` is 1, `link_value` equals the `cur_pc` of the request.
- R7: `delay_slot` follows `delayed` for jumps and conditional branches, whether or not they are taken. It is always 0 for breaks and always 1 for returns.
- R8: With `br_kind` = 2 (break), `taken` = 1, `next_pc` = `operand`, `link_we` = 1, and `msr_set` has only the break-in-progress bit set (bit `BIP_BIT`, default 3).
- R9: With `br_kind` = 3 (return), `taken` = 1 and `next_pc` = `reg_a` + `operand`. The status masks depend on `ret_kind`:
  - 1 sets only the interrupt-enable bit in `msr_set` (bit `IE_BIT`, default 1).
  - 2 sets only the break-in-progress bit in `msr_clr`.
  - 0 and 3 leave both masks zero.
- R10: Condition codes 6 and 7 never take the branch. They behave as a failed conditional branch.
- R11: `msr_set` and `msr_clr` are zero for jumps and conditional branches, and never share a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A branch request is present this cycle |
| cur_pc | input | 32 | Address of the branch instruction |
| reg_a | input | 32 | Register operand tested or used as return base |
| operand | input | 32 | Offset or absolute target (register or immediate) |
| br_kind | input | 2 | 0 jump, 1 conditional, 2 break, 3 return |
| cond_code | input | 3 | Condition select for conditional branches |
| absolute | input | 1 | Jump loads `operand` as the target |
| link | input | 1 | Jump writes the link register |
| delayed | input | 1 | Jump or conditional branch has a delay slot |
| ret_kind | input | 2 | 0 subroutine, 1 interrupt, 2 break return |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | Next fetch address after the branch |
| taken | output | 1 | The transfer was taken |
| delay_slot | output | 1 | The following instruction is a delay slot |
| link_we | output | 1 | Write `link_value` to the destination register |
| link_value | output | 32 | Branch address to be linked |
| msr_set | output | 32 | Status bits to set |
| msr_clr | output | 32 | Status bits to clear |

## Verification
Some properties are checked on every clock against the request registered one cycle earlier:
- the one-cycle result latency;
- the next address of a conditional branch, taken or falling through;
- unconditional taking of jumps;
- delay-slot marking for breaks and returns;
- the link value matching the request's branch address;
- the disjoint status masks.

Only the bench's scenarios show the rest. These are the truth table of all eight condition codes across negative, zero and positive operands, including the most negative and most positive values. They also cover address wraparound on fall-through, and the exact mask produced for each return flavour.

// File: rtl/bru_pkg.sv
// Shared encodings for the branch resolution unit.
// Assumes the decode stage produces these codes directly.
package bru_pkg;

    typedef enum logic [1:0] {
        BK_JUMP   = 2'd0,
        BK_COND   = 2'd1,
        BK_BREAK  = 2'd2,
        BK_RETURN = 2'd3
    } br_kind_e;

    typedef enum logic [2:0] {
        CC_EQ = 3'd0,
        CC_NE = 3'd1,
        CC_LT = 3'd2,
        CC_LE = 3'd3,
        CC_GT = 3'd4,
        CC_GE = 3'd5
    } cond_e;

    typedef enum logic [1:0] {
        RK_SUB   = 2'd0,
        RK_INTR  = 2'd1,
        RK_BREAK = 2'd2
    } ret_kind_e;

endpackage

// File: rtl/bru_cond_eval.sv
// Signed zero-compare of one register operand.
// Assumes two's complement; codes outside the six defined tests yield no hit.
module bru_cond_eval #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] value,
    input  logic [2:0]        code,
    output logic              hit
);
    import bru_pkg::*;

    logic is_zero;
    logic is_neg;

    assign is_zero = (value == '0);
    assign is_neg  = value[DATA_W-1];

    // Select the test named by the condition code.
    always_comb begin
        case (code)
            CC_EQ:   hit = is_zero;
            CC_NE:   hit = !is_zero;
            CC_LT:   hit = is_neg;
            CC_LE:   hit = is_neg || is_zero;
            CC_GT:   hit = !is_neg && !is_zero;
            CC_GE:   hit = !is_neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bru_target_gen.sv
// Next-address generator built around a single adder.
// Base is the branch address or the register operand; the addend is the
// offset or the instruction size; an absolute request bypasses the adder.
module bru_target_gen #(
    parameter int DATA_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] reg_base,
    input  logic [DATA_W-1:0] offset,
    input  logic              use_reg_base,
    input  logic              use_step,
    input  logic              use_abs,
    output logic [DATA_W-1:0] target
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] addend;

    // Choose adder inputs, then bypass for absolute targets.
    always_comb begin
        base   = use_reg_base ? reg_base : pc;
        addend = use_step ? STEP : offset;
        target = use_abs ? offset : (base + addend);
    end
endmodule

// File: rtl/bru_msr_effect.sv
// Status-register side effects of breaks and returns, as set/clear masks.
// Assumes both bit positions lie inside the status width.
module bru_msr_effect #(
    parameter int MSR_W   = 32,
    parameter int IE_BIT  = 1,
    parameter int BIP_BIT = 3
) (
    input  logic [1:0]       kind,
    input  logic [1:0]       rkind,
    output logic [MSR_W-1:0] set_mask,
    output logic [MSR_W-1:0] clr_mask
);
    import bru_pkg::*;

    localparam logic [MSR_W-1:0] IE_MASK  = MSR_W'(1) << IE_BIT;
    localparam logic [MSR_W-1:0] BIP_MASK = MSR_W'(1) << BIP_BIT;

    // Derive the masks from the branch kind and return flavour.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        if (kind == BK_BREAK) begin
            set_mask = BIP_MASK;
        end else if (kind == BK_RETURN) begin
            if (rkind == RK_INTR)  set_mask = IE_MASK;
            if (rkind == RK_BREAK) clr_mask = BIP_MASK;
        end
    end
endmodule

// File: rtl/branch_resolve.sv
// Branch and return resolution with delay-slot marking.
// Takes one decoded request per cycle and returns a registered result one
// clock later. Assumes the offset/target was already chosen from register
// or immediate by decode. Idle cycles produce an all-zero result.
module branch_resolve #(
    parameter int DATA_W     = 32,
    parameter int MSR_W      = 32,
    parameter int INSN_BYTES = 4,
    parameter int IE_BIT     = 1,
    parameter int BIP_BIT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] cur_pc,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] operand,
    input  logic [1:0]        br_kind,
    input  logic [2:0]        cond_code,
    input  logic              absolute,
    input  logic              link,
    input  logic              delayed,
    input  logic [1:0]        ret_kind,
    output logic              out_valid,
    output logic [DATA_W-1:0] next_pc,
    output logic              taken,
    output logic              delay_slot,
    output logic              link_we,
    output logic [DATA_W-1:0] link_value,
    output logic [MSR_W-1:0]  msr_set,
    output logic [MSR_W-1:0]  msr_clr
);
    import bru_pkg::*;

    logic              cond_hit;
    logic              c_taken;
    logic              c_delay;
    logic              c_link;
    logic              c_reg_base;
    logic              c_step;
    logic              c_abs;
    logic [DATA_W-1:0] c_target;
    logic [MSR_W-1:0]  c_set;
    logic [MSR_W-1:0]  c_clr;

    bru_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .value (reg_a),
        .code  (cond_code),
        .hit   (cond_hit)
    );

    // Per-kind control: which adder inputs, taken, link and delay slot.
    always_comb begin
        c_taken    = 1'b1;
        c_delay    = 1'b0;
        c_link     = 1'b0;
        c_reg_base = 1'b0;
        c_step     = 1'b0;
        c_abs      = 1'b0;
        case (br_kind)
            BK_JUMP: begin
                c_abs   = absolute;
                c_link  = link;
                c_delay = delayed;
            end
            BK_COND: begin
                c_taken = cond_hit;
                c_step  = !cond_hit;
                c_delay = delayed;
            end
            BK_BREAK: begin
                c_abs  = 1'b1;
                c_link = 1'b1;
            end
            default: begin
                c_reg_base = 1'b1;
                c_delay    = 1'b1;
            end
        endcase
    end

    bru_target_gen #(.DATA_W(DATA_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc           (cur_pc),
        .reg_base     (reg_a),
        .offset       (operand),
        .use_reg_base (c_reg_base),
        .use_step     (c_step),
        .use_abs      (c_abs),
        .target       (c_target)
    );

    bru_msr_effect #(.MSR_W(MSR_W), .IE_BIT(IE_BIT), .BIP_BIT(BIP_BIT)) u_msr (
        .kind     (br_kind),
        .rkind    (ret_kind),
        .set_mask (c_set),
        .clr_mask (c_clr)
    );

    // Result register: loaded on a request, cleared on reset and idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid  <= 1'b0;
            next_pc    <= '0;
            taken      <= 1'b0;
            delay_slot <= 1'b0;
            link_we    <= 1'b0;
            link_value <= '0;
            msr_set    <= '0;
            msr_clr    <= '0;
        end else begin
            out_valid  <= 1'b1;
            next_pc    <= c_target;
            taken      <= c_taken;
            delay_slot <= c_delay;
            link_we    <= c_link;
            link_value <= c_link ? cur_pc : '0;
            msr_set    <= c_set;
            msr_clr    <= c_clr;
        end
    end
endmodule

// File: rtl/bru_checker.sv
// Temporal checks for branch_resolve, attached by bind.
module bru_checker #(
    parameter int DATA_W     = 32,
    parameter int MSR_W      = 32,
    parameter int INSN_BYTES = 4,
    parameter int BIP_BIT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] cur_pc,
    input logic [DATA_W-1:0] operand,
    input logic [1:0]        br_kind,
    input logic              out_valid,
    input logic [DATA_W-1:0] next_pc,
    input logic              taken,
    input logic              delay_slot,
    input logic              link_we,
    input logic [DATA_W-1:0] link_value,
    input logic [MSR_W-1:0]  msr_set,
    input logic [MSR_W-1:0]  msr_clr
);
    localparam logic [DATA_W-1:0] STEP = DATA_W'(INSN_BYTES);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !link_we && next_pc == '0));

    assert_cond_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd1) |=>
            (taken ? (next_pc == $past(cur_pc) + $past(operand))
                   : (next_pc == $past(cur_pc) + STEP)));

    assert_jump_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd0) |=> taken);

    assert_link_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (!link_we || link_value == $past(cur_pc)));

    assert_break_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd2) |=> !delay_slot);

    assert_return_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd3) |=> delay_slot);

    assert_break_bip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && br_kind == 2'd2) |=> (msr_set[BIP_BIT] && link_we && taken));

    assert_mask_disjoint_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((msr_set & msr_clr) == '0));
endmodule

bind branch_resolve bru_checker #(
    .DATA_W(DATA_W), .MSR_W(MSR_W), .INSN_BYTES(INSN_BYTES), .BIP_BIT(BIP_BIT)
) u_bru_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
    .operand(operand), .br_kind(br_kind), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .delay_slot(delay_slot),
    .link_we(link_we), .link_value(link_value), .msr_set(msr_set),
    .msr_clr(msr_clr)
);

// File: tb/test_branch_resolve.sv
`timescale 1ns/1ps
module test_branch_resolve;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] cur_pc, reg_a, operand;
    logic [1:0]  br_kind, ret_kind;
    logic [2:0]  cond_code;
    logic        absolute, link, delayed;
    logic        out_valid, taken, delay_slot, link_we;
    logic [31:0] next_pc, link_value, msr_set, msr_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    branch_resolve i_branch_resolve (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
        .reg_a(reg_a), .operand(operand), .br_kind(br_kind),
        .cond_code(cond_code), .absolute(absolute), .link(link),
        .delayed(delayed), .ret_kind(ret_kind), .out_valid(out_valid),
        .next_pc(next_pc), .taken(taken), .delay_slot(delay_slot),
        .link_we(link_we), .link_value(link_value), .msr_set(msr_set),
        .msr_clr(msr_clr)
    );

    // Compare all outputs against an expected packed result.
    task automatic compare(input logic [163:0] exp, input string tag);
        logic [163:0] act;
        act = {out_valid, taken, delay_slot, link_we, next_pc, link_value, msr_set, msr_clr};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request for one clock and check the result the clock after.
    task automatic step(input logic v, input logic [31:0] pc, input logic [31:0] ra,
                        input logic [31:0] op, input logic [1:0] k, input logic [2:0] c,
                        input logic ab, input logic lk, input logic dl,
                        input logic [1:0] rk, input string tag);
        logic e_tk, e_ds, e_lw;
        logic [31:0] e_np, e_lv, e_set, e_clr;
        int signed sra;
        bit hold;
        in_valid = v; cur_pc = pc; reg_a = ra; operand = op; br_kind = k;
        cond_code = c; absolute = ab; link = lk; delayed = dl; ret_kind = rk;
        e_tk = 0; e_ds = 0; e_lw = 0; e_np = 0; e_lv = 0; e_set = 0; e_clr = 0;
        sra = ra;
        if (v) begin
            case (k)
                2'd0: begin e_tk = 1; e_np = ab ? op : pc + op; e_lw = lk; e_ds = dl; end
                2'd1: begin
                    case (c)
                        3'd0: hold = (sra == 0);
                        3'd1: hold = (sra != 0);
                        3'd2: hold = (sra < 0);
                        3'd3: hold = (sra <= 0);
                        3'd4: hold = (sra > 0);
                        3'd5: hold = (sra >= 0);
                        default: hold = 0;
                    endcase
                    e_tk = hold; e_np = hold ? pc + op : pc + 32'd4; e_ds = dl;
                end
                2'd2: begin e_tk = 1; e_np = op; e_lw = 1; e_set = 32'h8; end
                default: begin
                    e_tk = 1; e_np = ra + op; e_ds = 1;
                    if (rk == 2'd1) e_set = 32'h2;
                    if (rk == 2'd2) e_clr = 32'h8;
                end
            endcase
            if (e_lw) e_lv = pc;
        end
        @(negedge clk);
        compare({v, e_tk, e_ds, e_lw, e_np, e_lv, e_set, e_clr}, tag);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] ras [4];
        ras[0] = 32'h0000_0000; ras[1] = 32'hFFFF_FFFF;
        ras[2] = 32'h8000_0000; ras[3] = 32'h7FFF_FFFF;
        rst_n = 0; in_valid = 1; cur_pc = 32'h1234; reg_a = 0; operand = 32'h40;
        br_kind = 0; cond_code = 0; absolute = 0; link = 1; delayed = 1; ret_kind = 0;
        repeat (3) @(negedge clk);
        compare('0, "R1 reset");
        rst_n = 1;
        step(0, 32'h100, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle");
        // R3 R4 R10: every code against zero, negative, both extremes
        for (int c = 0; c < 8; c++)
            for (int r = 0; r < 4; r++)
                step(1, 32'h2000 + 32'(c * 64 + r * 8), ras[r], 32'hFFFF_FFF0, 2'd1,
                     3'(c), 0, 0, 1'(r & 1), 0, c > 5 ? "R10 unused code" : "R3 R4 cond");
        step(1, 32'h0000_0040, 32'd5, 32'h100, 2'd1, 3'd4, 0, 0, 0, 0, "R3 gt positive");
        step(1, 32'hFFFF_FFFC, 32'd5, 32'h100, 2'd1, 3'd0, 0, 0, 1, 0, "R4 fallthrough wrap");
        // R5 R6 R7: jump variants
        for (int m = 0; m < 8; m++)
            step(1, 32'h3000, 32'h9, 32'h0000_0200, 2'd0, 0, 1'(m >> 2), 1'(m >> 1), 1'(m), 0,
                 "R5 R6 R7 jump");
        step(1, 32'h3000, 0, 32'hFFFF_FF00, 2'd0, 0, 0, 1, 0, 0, "R5 negative offset");
        step(1, 32'h4000, 32'h55, 32'h0000_0018, 2'd2, 0, 0, 0, 1, 0, "R8 break");
        for (int k = 0; k < 4; k++)
            step(1, 32'h5000, 32'h6000, 32'h8, 2'd3, 0, 1, 1, 0, 2'(k), "R9 return");
        step(1, 32'h5000, 32'h6000, 32'h8, 2'd3, 0, 0, 0, 0, 2'd1, "R11 return intr");
        step(0, 32'h5000, 32'h6000, 32'h8, 2'd2, 0, 0, 0, 0, 0, "R2 idle after break");
        step(1, 32'h7000, 0, 32'h10, 2'd1, 3'd1, 0, 0, 0, 0, "R4 R11 ne on zero");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule